// File: doc/BRIEF.md
# Clock Output Shutdown and Suspend Controller

This block decides, on every reference-clock cycle, which clock-generation resources of a multi-PLL clock generator are powered and which output drivers are allowed to drive. It watches two active-low pins. The output-enable/shutdown pin always tri-states every output when low; a configuration bit decides whether that low also powers down the reference oscillator, every PLL and every counter. The second pin is shared with frequency-select bit 2: only when suspend mode is configured does a low on it suspend a programmed set of PLLs and a programmed set of outputs. Otherwise the pin is passed on, synchronized, as an ordinary select bit.

Each output has a source code in its configuration: code 0 selects the reference, code k (1..N_PLL) selects PLL k-1, and any other code selects nothing. An output is released only when its source is running and, for a PLL source, after that PLL's lock timer has expired since it was last enabled. The suspend masks are checked for consistency. If an output that stays active would be fed by a PLL that suspend turns off, an error flag is raised and every output is held off. Both pins pass through a two-flop synchronizer, and all enables change only on the reference clock.

Top module: `clkgate_pwr_ctrl`

## Requirements
- R1: A low on `oe_pin_n` drives every bit of `out_en` to 0. Returning the pin high restores the enables without a relock when the PLLs stayed powered.
- R2: With `cfg_full_shdn`=1, a low on `oe_pin_n` drives `osc_en` and every `pll_en` bit to 0. With `cfg_full_shdn`=0, the same low leaves `osc_en` and `pll_en` unchanged.
- R3: A change on either pin reaches the registered outputs on the third rising clock edge after it is first sampled (two synchronizer stages and one output register), far inside a 300 ns bound.
- R4: `sel2_susp_pin` acts as active-low suspend only while `cfg_susp_mode`=1, and `sel2_out` is then 0. While `cfg_susp_mode`=0, `sel2_out` follows the synchronized pin and the pin changes no enable.
- R5: While suspend is active, PLL p with `cfg_susp_pll[p]`=1 has `pll_en[p]`=0 and output o with `cfg_susp_out[o]`=1 has `out_en[o]`=0. Unmasked PLLs stay enabled and do not restart their lock count.
- R6: `cfg_err` is 1, one cycle after the configuration, whenever some output with `cfg_susp_out[o]`=0 has a source code naming a PLL with `cfg_susp_pll` set. While `cfg_err` is 1, `out_en` is all 0.
- R7: Source field of output o is `cfg_out_src[o*SRC_W +: SRC_W]`. Code 0 is the reference, code k in 1..N_PLL is PLL k-1, and any other code keeps that output disabled.
- R8: When a PLL's enable rises, its `lock_pending` bit is 1 for exactly `cfg_lock_len`+1 cycles. Outputs sourced from it are enabled one cycle after `lock_pending` falls, and never while it is 1.
- R9: During reset, `osc_en`, `pll_en`, `lock_pending`, `out_en`, `sel2_out` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_pin_n | input | 1 | Output-enable / shutdown pin, active low, asynchronous |
| sel2_susp_pin | input | 1 | Select bit 2 or suspend (active low), asynchronous |
| cfg_full_shdn | input | 1 | 1: a low `oe_pin_n` also powers down oscillator and PLLs |
| cfg_susp_mode | input | 1 | 1: shared pin acts as suspend |
| cfg_susp_pll | input | N_PLL | PLLs turned off by suspend |
| cfg_susp_out | input | N_OUT | Outputs tri-stated by suspend |
| cfg_out_src | input | N_OUT*SRC_W | Per-output source code |
| cfg_lock_len | input | LOCK_W | Lock wait length in cycles |
| osc_en | output | 1 | Reference oscillator enable |
| pll_en | output | N_PLL | Per-PLL power enable |
| lock_pending | output | N_PLL | PLL enabled but lock wait not yet expired |
| out_en | output | N_OUT | Per-output driver enable (0 = high impedance) |
| sel2_out | output | 1 | Synchronized select bit 2 (0 in suspend mode) |
| cfg_err | output | 1 | Suspend masks inconsistent |

## Verification
A corrupted synchronizer or output register shows up as an `out_en` or `pll_en` edge one or more cycles off from the three-edge pin latency. The bench compares the outputs every cycle, so such a fault is seen at the first pin change. A lock counter that loads, decrements or finishes wrongly changes how long `lock_pending` stays high, and the PLL outputs then rise early or late. Full shutdown followed by release makes this visible within `cfg_lock_len`+4 cycles. A wrong routing decode or mask check shows as a wrong `cfg_err` or a wrong `out_en` pattern one cycle after the configuration changes.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    typedef enum logic [1:0] {
        SRC_KIND_REF  = 2'd0,
        SRC_KIND_PLL  = 2'd1,
        SRC_KIND_NONE = 2'd2
    } src_kind_e;

    // Classify a source code: 0 = reference, 1..n_pll = PLL, else none.
    function automatic src_kind_e src_kind(input int unsigned code, input int unsigned n_pll);
        if (code == 0) begin
            return SRC_KIND_REF;
        end else if (code <= n_pll) begin
            return SRC_KIND_PLL;
        end
        return SRC_KIND_NONE;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage1: RST_VAL, stage2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stage2;

endmodule

// File: rtl/clkgate_lock_timer.sv
`timescale 1ns/1ps
module clkgate_lock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic [CNT_W-1:0] wait_len,
    output logic             pll_on,
    output logic             locked,
    output logic             pending
);

    typedef struct packed {
        logic             on;
        logic             locked;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d    = tm_q;
        tm_d.on = en_req;
        if (!en_req) begin
            tm_d.locked = 1'b0;
            tm_d.cnt    = '0;
        end else if (!tm_q.on) begin
            // fresh power-up: start the lock wait
            tm_d.locked = 1'b0;
            tm_d.cnt    = wait_len;
        end else if (!tm_q.locked) begin
            if (tm_q.cnt == '0) begin
                tm_d.locked = 1'b1;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign pll_on  = tm_q.on;
    assign locked  = tm_q.locked;
    assign pending = tm_q.on & ~tm_q.locked;

endmodule

// File: rtl/clkgate_route.sv
`timescale 1ns/1ps
module clkgate_route
    import clkgate_pkg::*;
#(
    parameter int N_PLL = 3,
    parameter int N_OUT = 6,
    parameter int SRC_W = 3
) (
    input  logic [N_OUT*SRC_W-1:0] out_src,
    input  logic [N_OUT-1:0]       out_mask,
    input  logic [N_PLL-1:0]       pll_mask,
    input  logic [N_PLL-1:0]       pll_req,
    input  logic [N_PLL-1:0]       pll_locked,
    output logic [N_OUT-1:0]       src_ready,
    output logic                   mask_err
);

    logic [N_OUT-1:0] err_per_out;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [SRC_W-1:0] code;
        assign code = out_src[o*SRC_W +: SRC_W];

        always_comb begin
            src_ready[o]   = 1'b0;
            err_per_out[o] = 1'b0;
            unique case (src_kind(int'(code), N_PLL))
                SRC_KIND_REF:  src_ready[o] = 1'b1;
                SRC_KIND_PLL: begin
                    for (int p = 0; p < N_PLL; p++) begin
                        if (code == SRC_W'(p + 1)) begin
                            src_ready[o]   = pll_req[p] & pll_locked[p];
                            err_per_out[o] = ~out_mask[o] & pll_mask[p];
                        end
                    end
                end
                default:       src_ready[o] = 1'b0;
            endcase
        end
    end

    assign mask_err = |err_per_out;

endmodule

// File: rtl/clkgate_pwr_ctrl.sv
`timescale 1ns/1ps
module clkgate_pwr_ctrl #(
    parameter int   N_PLL  = 3,
    parameter int   N_OUT  = 6,
    parameter int   LOCK_W = 16,
    localparam int  SRC_W  = $clog2(N_PLL + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   oe_pin_n,
    input  logic                   sel2_susp_pin,
    input  logic                   cfg_full_shdn,
    input  logic                   cfg_susp_mode,
    input  logic [N_PLL-1:0]       cfg_susp_pll,
    input  logic [N_OUT-1:0]       cfg_susp_out,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input  logic [LOCK_W-1:0]      cfg_lock_len,
    output logic                   osc_en,
    output logic [N_PLL-1:0]       pll_en,
    output logic [N_PLL-1:0]       lock_pending,
    output logic [N_OUT-1:0]       out_en,
    output logic                   sel2_out,
    output logic                   cfg_err
);

    typedef struct packed {
        logic             osc_en;
        logic [N_OUT-1:0] out_en;
        logic             sel2;
        logic             err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [1:0]       pins_sync;
    logic             oe_s, sp_s;
    logic             shut, full_down, susp_act;
    logic [N_PLL-1:0] pll_req, pll_locked;
    logic [N_OUT-1:0] src_ready;
    logic             mask_err;

    clkgate_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sel2_susp_pin, oe_pin_n}),
        .sync_out (pins_sync)
    );

    assign oe_s = pins_sync[0];
    assign sp_s = pins_sync[1];

    assign shut      = ~oe_s;
    assign full_down = shut & cfg_full_shdn;
    assign susp_act  = cfg_susp_mode & ~sp_s;

    for (genvar p = 0; p < N_PLL; p++) begin : g_pll
        assign pll_req[p] = ~full_down & ~(susp_act & cfg_susp_pll[p]);

        clkgate_lock_timer #(.CNT_W(LOCK_W)) u_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_req   (pll_req[p]),
            .wait_len (cfg_lock_len),
            .pll_on   (pll_en[p]),
            .locked   (pll_locked[p]),
            .pending  (lock_pending[p])
        );
    end

    clkgate_route #(.N_PLL(N_PLL), .N_OUT(N_OUT), .SRC_W(SRC_W)) u_route (
        .out_src    (cfg_out_src),
        .out_mask   (cfg_susp_out),
        .pll_mask   (cfg_susp_pll),
        .pll_req    (pll_req),
        .pll_locked (pll_locked),
        .src_ready  (src_ready),
        .mask_err   (mask_err)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.osc_en = ~full_down;
        ctl_d.sel2   = ~cfg_susp_mode & sp_s;
        ctl_d.err    = mask_err;
        for (int o = 0; o < N_OUT; o++) begin
            ctl_d.out_en[o] = ~shut
                            & ~(susp_act & cfg_susp_out[o])
                            & ~mask_err
                            & src_ready[o];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign osc_en   = ctl_q.osc_en;
    assign out_en   = ctl_q.out_en;
    assign sel2_out = ctl_q.sel2;
    assign cfg_err  = ctl_q.err;

endmodule

// File: rtl/clkgate_pwr_ctrl_chk.sv
`timescale 1ns/1ps
module clkgate_pwr_ctrl_chk #(
    parameter int  N_PLL  = 3,
    parameter int  N_OUT  = 6,
    parameter int  LOCK_W = 16,
    localparam int SRC_W  = $clog2(N_PLL + 2)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   oe_pin_n,
    input logic                   sel2_susp_pin,
    input logic                   cfg_full_shdn,
    input logic                   cfg_susp_mode,
    input logic [N_PLL-1:0]       cfg_susp_pll,
    input logic [N_OUT-1:0]       cfg_susp_out,
    input logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input logic [LOCK_W-1:0]      cfg_lock_len,
    input logic                   osc_en,
    input logic [N_PLL-1:0]       pll_en,
    input logic [N_PLL-1:0]       lock_pending,
    input logic [N_OUT-1:0]       out_en,
    input logic                   sel2_out,
    input logic                   cfg_err
);

    // cycles since reset, saturating; past-based checks wait for history
    logic [2:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    assign warm = (age_q >= 3'd4);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (out_en == '0 && pll_en == '0 && !osc_en && !cfg_err));

    assert_oe_tristate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(oe_pin_n, 3)) |-> (out_en == '0));

    assert_full_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(oe_pin_n, 3) && $past(cfg_full_shdn)) |-> (pll_en == '0 && !osc_en));

    assert_osc_before_pll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (pll_en == '0));

    assert_select_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(cfg_susp_mode)) |-> !sel2_out);

    assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (out_en == '0));

    for (genvar p = 0; p < N_PLL; p++) begin : g_pll_chk
        assert_pending_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
            lock_pending[p] |-> pll_en[p]);

        assert_susp_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && $past(cfg_susp_mode) && !$past(sel2_susp_pin, 3) && $past(cfg_susp_pll[p]))
            |-> !pll_en[p]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        for (genvar p = 0; p < N_PLL; p++) begin : g_src
            assert_src_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (out_en[o] && $past(cfg_out_src[o*SRC_W +: SRC_W]) == SRC_W'(p + 1))
                |-> (pll_en[p] && !lock_pending[p]));
        end

        assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cfg_out_src[o*SRC_W +: SRC_W]) > SRC_W'(N_PLL)) |-> !out_en[o]);
    end

endmodule

bind clkgate_pwr_ctrl clkgate_pwr_ctrl_chk #(
    .N_PLL  (N_PLL),
    .N_OUT  (N_OUT),
    .LOCK_W (LOCK_W)
) u_chk (.*);

// File: tb/clkgate_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_pwr_ctrl_bench;

    localparam int NP = 3;
    localparam int NO = 6;
    localparam int LW = 16;
    localparam int SW = $clog2(NP + 2);
    localparam int LOCKLEN = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oe_pin_n = 1'b1;
    logic          sel2_susp_pin = 1'b1;
    logic          cfg_full_shdn = 1'b0;
    logic          cfg_susp_mode = 1'b0;
    logic [NP-1:0] cfg_susp_pll = '0;
    logic [NO-1:0] cfg_susp_out = '0;
    logic [NO*SW-1:0] cfg_out_src;
    logic [LW-1:0] cfg_lock_len = LW'(LOCKLEN);
    logic          osc_en;
    logic [NP-1:0] pll_en, lock_pending;
    logic [NO-1:0] out_en;
    logic          sel2_out, cfg_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkgate_pwr_ctrl #(.N_PLL(NP), .N_OUT(NO), .LOCK_W(LW)) u_clkgate_pwr_ctrl (
        .clk, .rst_n, .oe_pin_n, .sel2_susp_pin, .cfg_full_shdn, .cfg_susp_mode,
        .cfg_susp_pll, .cfg_susp_out, .cfg_out_src, .cfg_lock_len,
        .osc_en, .pll_en, .lock_pending, .out_en, .sel2_out, .cfg_err
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_oe[$];
    int m_sp[$];
    bit m_on[NP], m_lck[NP];
    int m_cnt[NP];
    bit [NO-1:0] e_out;
    bit e_osc, e_sel2, e_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_oe = '{1, 1};
            m_sp = '{1, 1};
            for (int p = 0; p < NP; p++) begin
                m_on[p] = 0; m_lck[p] = 0; m_cnt[p] = 0;
            end
            e_out = '0; e_osc = 0; e_sel2 = 0; e_err = 0;
        end else begin
            bit shut, full, susp, err;
            bit req[NP];
            bit [NO-1:0] nxt;
            shut = (m_oe[0] == 0);
            full = shut && cfg_full_shdn;
            susp = cfg_susp_mode && (m_sp[0] == 0);
            for (int p = 0; p < NP; p++) req[p] = !full && !(susp && cfg_susp_pll[p]);
            err = 0;
            for (int o = 0; o < NO; o++) begin
                int code;
                bit rdy;
                code = int'(cfg_out_src[o*SW +: SW]);
                if (code == 0) rdy = 1;
                else if (code <= NP) begin
                    rdy = req[code-1] && m_lck[code-1];
                    if (!cfg_susp_out[o] && cfg_susp_pll[code-1]) err = 1;
                end else rdy = 0;
                nxt[o] = !shut && !(susp && cfg_susp_out[o]) && rdy;
            end
            e_out  = err ? '0 : nxt;
            e_err  = err;
            e_osc  = !full;
            e_sel2 = !cfg_susp_mode && (m_sp[0] == 1);
            for (int p = 0; p < NP; p++) begin
                if (!req[p]) begin
                    m_on[p] = 0; m_lck[p] = 0; m_cnt[p] = 0;
                end else if (!m_on[p]) begin
                    m_on[p] = 1; m_lck[p] = 0; m_cnt[p] = int'(cfg_lock_len);
                end else if (!m_lck[p]) begin
                    if (m_cnt[p] == 0) m_lck[p] = 1;
                    else m_cnt[p] = m_cnt[p] - 1;
                end
            end
            void'(m_oe.pop_front());
            m_oe.push_back(int'(oe_pin_n));
            void'(m_sp.pop_front());
            m_sp.push_back(int'(sel2_susp_pin));
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [NP-1:0] e_pll, e_pend;
            for (int p = 0; p < NP; p++) begin
                e_pll[p]  = m_on[p];
                e_pend[p] = m_on[p] && !m_lck[p];
            end
            check("R1 out_en vs model", int'(out_en), int'(e_out));
            check("R2 pll_en vs model", int'(pll_en), int'(e_pll));
            check("R2 osc_en vs model", int'(osc_en), int'(e_osc));
            check("R8 lock_pending vs model", int'(lock_pending), int'(e_pend));
            check("R4 sel2_out vs model", int'(sel2_out), int'(e_sel2));
            check("R6 cfg_err vs model", int'(cfg_err), int'(e_err));
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus and directed checks ----------------
    initial begin
        // out0=ref, out1=PLL0, out2=PLL1, out3=PLL2, out4=PLL0, out5=invalid code 7
        cfg_out_src = {3'd7, 3'd1, 3'd3, 3'd2, 3'd1, 3'd0};
        ticks(4);
        check("R9 reset out_en", int'(out_en), 0);
        check("R9 reset pll_en", int'(pll_en), 0);
        check("R9 reset flags", int'({osc_en, sel2_out, cfg_err, lock_pending}), 0);
        rst_n = 1'b1;
        ticks(20);
        check("R8 all locked after start", int'(out_en), 'b011111);
        check("R7 invalid source stays off", int'(out_en[5]), 0);

        // R3 latency with output-only shutdown
        oe_pin_n = 1'b0;
        ticks(2);
        check("R3 out_en still on at edge 2", int'(out_en), 'b011111);
        ticks(1);
        check("R1 tri-state at edge 3", int'(out_en), 0);
        check("R2 PLLs kept without full shutdown", int'(pll_en), 'b111);
        check("R2 osc kept without full shutdown", int'(osc_en), 1);
        oe_pin_n = 1'b1;
        ticks(3);
        check("R1 restore without relock", int'(out_en), 'b011111);

        // full shutdown and relock
        cfg_full_shdn = 1'b1;
        oe_pin_n = 1'b0;
        ticks(5);
        check("R2 PLLs off in full shutdown", int'(pll_en), 0);
        check("R2 osc off in full shutdown", int'(osc_en), 0);
        oe_pin_n = 1'b1;
        ticks(3);
        check("R3 PLLs back at edge 3", int'(pll_en), 'b111);
        check("R8 pending after power-up", int'(lock_pending), 'b111);
        ticks(5);
        check("R8 pending lasts len+1", int'(lock_pending), 'b111);
        ticks(1);
        check("R8 pending cleared", int'(lock_pending), 0);
        check("R8 only reference output early", int'(out_en), 'b000001);
        ticks(1);
        check("R8 PLL outputs released", int'(out_en), 'b011111);
        cfg_full_shdn = 1'b0;

        // select-bit mode: pin is passed through
        sel2_susp_pin = 1'b0;
        ticks(3);
        check("R4 sel2 follows pin low", int'(sel2_out), 0);
        check("R4 no suspend effect on outputs", int'(out_en), 'b011111);
        check("R4 no suspend effect on PLLs", int'(pll_en), 'b111);
        sel2_susp_pin = 1'b1;
        ticks(3);
        check("R4 sel2 follows pin high", int'(sel2_out), 1);

        // suspend mode: PLL0 and its outputs
        cfg_susp_pll = 3'b001;
        cfg_susp_out = 6'b010010;
        cfg_susp_mode = 1'b1;
        ticks(1);
        check("R4 sel2 forced low in suspend mode", int'(sel2_out), 0);
        check("R6 consistent masks", int'(cfg_err), 0);
        sel2_susp_pin = 1'b0;
        ticks(3);
        check("R5 masked PLL off", int'(pll_en), 'b110);
        check("R5 masked outputs off", int'(out_en), 'b001101);
        check("R5 other PLLs keep lock", int'(lock_pending), 0);

        // inconsistent mask
        cfg_susp_out = 6'b000010;
        ticks(1);
        check("R6 error raised", int'(cfg_err), 1);
        check("R6 outputs forced off", int'(out_en), 0);
        cfg_susp_out = 6'b010010;
        ticks(1);
        check("R6 error cleared", int'(cfg_err), 0);
        check("R6 outputs back", int'(out_en), 'b001101);

        // leave suspend: PLL0 relocks
        sel2_susp_pin = 1'b1;
        ticks(3);
        check("R5 PLL0 back on", int'(pll_en), 'b111);
        check("R8 PLL0 pending", int'(lock_pending), 'b001);
        ticks(7);
        check("R8 PLL0 outputs after relock", int'(out_en), 'b011111);

        ticks(5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule